// File: doc/BRIEF.md
# SDRAM Command Spacing Gate

This block sits between an SDRAM command scheduler and the memory command pins. The scheduler offers one command at a time on a valid/ready request port: activate, read, write, precharge or auto-refresh. The gate holds the command back until every minimum spacing that applies to it has elapsed. The command is then presented on the output in the same cycle as the handshake completes.

The spacings come from a 16-bit timing word that software writes. The word sets four delays through compact 2-bit codes. In these codes zero selects the longest delay, and reserved codes fall back to the longest delay of their field. The word also sets the column count, which the gate reports as a column address width. It also sets the CAS latency, which the gate uses to raise a one-cycle read-data-valid strobe a fixed number of cycles after each read. After every refresh, all commands other than refresh are locked out for 15 cycles.

Back-pressure rules: `req_ready` is a function of `req_cmd` and the internal timers only, and never of `req_valid`. A command transfers on a cycle where both `req_valid` and `req_ready` are high. The scheduler may change `req_cmd` while waiting. A request that is not accepted leaves no trace.

Top module: `sdram_cmd_gate`

## Requirements
- R1: After reset the timing word reads 0x0000, `col_bits` is 8, `rd_valid` is low, and activate, read, precharge and refresh requests each see `req_ready` high.
- R2: A command transfers on a cycle with `req_valid` and `req_ready` both high, and `cmd_valid`/`cmd_code` show it on that cycle. Command codes are 1 = activate, 2 = read, 3 = write, 4 = precharge, 5 = refresh. Codes 0, 6 and 7 never see `req_ready`. A request whose `req_valid` is low starts no timer.
- R3: A write stores bits 10:0 of the timing word, effective from the next cycle. Bits 15:11 always read back as zero.
- R4: Column code bits 1:0 give `col_bits` of 8 (00), 9 (01) or 10 (10).
- R5: Bit 2 sets the CAS latency to 2 (0) or 3 (1) cycles. `rd_valid` pulses for exactly one cycle, that many cycles after the cycle a read transfers. Writes raise no strobe.
- R6: Bits 4:3 set the activate-to-read/write spacing: 10 gives 2 cycles, 11 gives 3, 00 gives 4.
- R7: Bits 6:5 set the read/write-to-precharge spacing: 01 gives 1, 10 gives 2, 11 gives 3, 00 gives 4.
- R8: Bits 8:7 set the precharge-to-any-command spacing, with the same code as R7.
- R9: Bits 10:9 set the refresh-to-refresh spacing: 10 gives 3, 11 gives 7, 00 gives 15.
- R10: A command other than refresh transfers no sooner than 15 cycles after a refresh.
- R11: Reserved codes take the longest delay of their field: 01 in bits 4:3 gives 4 cycles, 01 in bits 10:9 gives 15, and column code 11 gives `col_bits` of 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Timing word write enable |
| cfg_wdata | input | 16 | Timing word write value |
| cfg_rdata | output | 16 | Timing word read-back |
| req_valid | input | 1 | Scheduler offers a command |
| req_cmd | input | 3 | Offered command code |
| req_ready | output | 1 | Offered command may transfer this cycle |
| cmd_valid | output | 1 | Command issued to the memory this cycle |
| cmd_code | output | 3 | Issued command code |
| rd_valid | output | 1 | Read data valid strobe |
| col_bits | output | 4 | Column address width in bits |

## Verification
The handshake outputs are combinational, so `req_ready` and `cmd_valid` are checked in the same cycle that the request is driven. A spacing of N cycles shows up as `req_ready` going high N sampling periods after the edge that accepted the first command. The bench counts those periods one at a time and expects exactly N. `rd_valid` is due 2 or 3 periods after the accepting edge. The bench samples it in each of the six periods that follow, which checks both its position and that it is a single pulse. Register writes are read back one period after the write edge.

// File: rtl/sdram_gate_pkg.sv
package sdram_gate_pkg;

  localparam int CMD_W = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } gate_cmd_e;

  // Timer slots
  localparam int N_TIMERS    = 5;
  localparam int T_ACT2RW    = 0;
  localparam int T_RW2PRE    = 1;
  localparam int T_PRE2ANY   = 2;
  localparam int T_REF2REF   = 3;
  localparam int T_REF2ANY   = 4;

  typedef logic [N_TIMERS-1:0] timer_mask_t;

  // Which timers must be idle before a command may transfer
  function automatic timer_mask_t gating_mask(input logic [CMD_W-1:0] c);
    timer_mask_t m;
    m = '0;
    case (c)
      CMD_ACT: begin
        m[T_PRE2ANY] = 1'b1;
        m[T_REF2ANY] = 1'b1;
      end
      CMD_RD, CMD_WR: begin
        m[T_ACT2RW]  = 1'b1;
        m[T_PRE2ANY] = 1'b1;
        m[T_REF2ANY] = 1'b1;
      end
      CMD_PRE: begin
        m[T_RW2PRE]  = 1'b1;
        m[T_PRE2ANY] = 1'b1;
        m[T_REF2ANY] = 1'b1;
      end
      CMD_REF: begin
        m[T_PRE2ANY] = 1'b1;
        m[T_REF2REF] = 1'b1;
      end
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic logic cmd_legal(input logic [CMD_W-1:0] c);
    return (c == CMD_ACT) || (c == CMD_RD) || (c == CMD_WR) ||
           (c == CMD_PRE) || (c == CMD_REF);
  endfunction

endpackage

// File: rtl/sgate_cfg_reg.sv
module sgate_cfg_reg #(
  parameter int CFG_W = 16,
  parameter int CNT_W = 4,
  parameter int LIVE_BITS = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output logic [3:0]       col_bits,
  output logic [1:0]       cas_lat,
  output logic [CNT_W-1:0] d_act2rw,
  output logic [CNT_W-1:0] d_rw2pre,
  output logic [CNT_W-1:0] d_pre2any,
  output logic [CNT_W-1:0] d_ref2ref
);

  localparam logic [CFG_W-1:0] WR_MASK = CFG_W'((1 << LIVE_BITS) - 1);

  logic [CFG_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  word_q <= '0;
    else if (we) word_q <= wdata & WR_MASK;
  end

  assign rdata = word_q;

  // Column width; reserved code falls to the widest
  always_comb begin
    case (word_q[1:0])
      2'b00:   col_bits = 4'd8;
      2'b01:   col_bits = 4'd9;
      default: col_bits = 4'd10;
    endcase
  end

  assign cas_lat = word_q[2] ? 2'd3 : 2'd2;

  // Activate to read/write; reserved 01 joins 00 at the longest
  always_comb begin
    case (word_q[4:3])
      2'b10:   d_act2rw = CNT_W'(2);
      2'b11:   d_act2rw = CNT_W'(3);
      default: d_act2rw = CNT_W'(4);
    endcase
  end

  function automatic logic [CNT_W-1:0] short_code(input logic [1:0] c);
    return (c == 2'b00) ? CNT_W'(4) : CNT_W'(c);
  endfunction

  assign d_rw2pre  = short_code(word_q[6:5]);
  assign d_pre2any = short_code(word_q[8:7]);

  // Refresh to refresh; reserved 01 joins 00 at the longest
  always_comb begin
    case (word_q[10:9])
      2'b10:   d_ref2ref = CNT_W'(3);
      2'b11:   d_ref2ref = CNT_W'(7);
      default: d_ref2ref = CNT_W'(15);
    endcase
  end

endmodule

// File: rtl/sgate_gap_cnt.sv
module sgate_gap_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             idle
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign idle = (cnt_q == '0);

endmodule

// File: rtl/sgate_cas_pipe.sv
module sgate_cas_pipe #(
  parameter int MAX_CL = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic [1:0] cas_lat,
  output logic       strobe
);

  localparam int SEL_W = (MAX_CL > 1) ? $clog2(MAX_CL) : 1;

  logic [MAX_CL-1:0] sr_q;
  logic [SEL_W-1:0]  sel;

  always_ff @(posedge clk) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[MAX_CL-2:0], fire};
  end

  assign sel    = SEL_W'(cas_lat - 2'd1);
  assign strobe = sr_q[sel];

endmodule

// File: rtl/sdram_cmd_gate.sv
module sdram_cmd_gate
  import sdram_gate_pkg::*;
#(
  parameter int CFG_W    = 16,
  parameter int REF_LOCK = 15,
  parameter int MAX_CL   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             req_valid,
  input  logic [2:0]       req_cmd,
  output logic             req_ready,
  output logic             cmd_valid,
  output logic [2:0]       cmd_code,
  output logic             rd_valid,
  output logic [3:0]       col_bits
);

  localparam int CNT_W = $clog2(REF_LOCK + 1);

  logic [1:0]       cas_lat;
  logic [CNT_W-1:0] d_act2rw, d_rw2pre, d_pre2any, d_ref2ref;
  logic             grant;
  logic [N_TIMERS-1:0] t_idle;
  logic [N_TIMERS-1:0] t_load;
  logic [CNT_W-1:0]    t_val [N_TIMERS];
  timer_mask_t         need;

  sgate_cfg_reg #(.CFG_W(CFG_W), .CNT_W(CNT_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (cfg_we),
    .wdata     (cfg_wdata),
    .rdata     (cfg_rdata),
    .col_bits  (col_bits),
    .cas_lat   (cas_lat),
    .d_act2rw  (d_act2rw),
    .d_rw2pre  (d_rw2pre),
    .d_pre2any (d_pre2any),
    .d_ref2ref (d_ref2ref)
  );

  // Handshake: ready depends on the offered code and the timers only
  assign need      = gating_mask(req_cmd);
  assign req_ready = cmd_legal(req_cmd) && ((need & ~t_idle) == '0);
  assign grant     = req_valid && req_ready;
  assign cmd_valid = grant;
  assign cmd_code  = req_cmd;

  // Timer loads; a spacing of N loads N-1 so the Nth cycle is free
  always_comb begin
    t_load[T_ACT2RW]  = grant && (req_cmd == CMD_ACT);
    t_load[T_RW2PRE]  = grant && ((req_cmd == CMD_RD) || (req_cmd == CMD_WR));
    t_load[T_PRE2ANY] = grant && (req_cmd == CMD_PRE);
    t_load[T_REF2REF] = grant && (req_cmd == CMD_REF);
    t_load[T_REF2ANY] = grant && (req_cmd == CMD_REF);
    t_val[T_ACT2RW]   = d_act2rw  - 1'b1;
    t_val[T_RW2PRE]   = d_rw2pre  - 1'b1;
    t_val[T_PRE2ANY]  = d_pre2any - 1'b1;
    t_val[T_REF2REF]  = d_ref2ref - 1'b1;
    t_val[T_REF2ANY]  = CNT_W'(REF_LOCK - 1);
  end

  for (genvar i = 0; i < N_TIMERS; i++) begin : g_timer
    sgate_gap_cnt #(.CNT_W(CNT_W)) u_gap (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load[i]),
      .load_val (t_val[i]),
      .idle     (t_idle[i])
    );
  end

  sgate_cas_pipe #(.MAX_CL(MAX_CL)) u_cas (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (grant && (req_cmd == CMD_RD)),
    .cas_lat (cas_lat),
    .strobe  (rd_valid)
  );

endmodule

// File: rtl/sdram_cmd_gate_chk.sv
module sdram_cmd_gate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cfg_rdata,
  input logic        req_ready,
  input logic [2:0]  req_cmd,
  input logic        cmd_valid,
  input logic [2:0]  cmd_code,
  input logic        rd_valid,
  input logic [3:0]  col_bits
);

  logic [3:0] since_ref_q, since_act_q;
  logic       rd_go;

  assign rd_go = cmd_valid && (cmd_code == 3'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_ref_q <= 4'd15;
      since_act_q <= 4'd15;
    end else begin
      if (cmd_valid && cmd_code == 3'd5) since_ref_q <= 4'd1;
      else if (since_ref_q != 4'd15)     since_ref_q <= since_ref_q + 4'd1;
      if (cmd_valid && cmd_code == 3'd1) since_act_q <= 4'd1;
      else if (since_act_q != 4'd15)     since_act_q <= since_act_q + 4'd1;
    end
  end

  // R2: only legal codes may see ready
  p_ready_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (req_cmd >= 3'd1 && req_cmd <= 3'd5));

  // R3: upper bits of the timing word stay zero
  p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[15:11] == 5'd0);

  // R4: column width is one of the three legal values
  p_col_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (col_bits == 4'd8) || (col_bits == 4'd9) || (col_bits == 4'd10));

  // R5: every strobe follows a read by two or three cycles
  p_strobe_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(rd_go, 2) || $past(rd_go, 3)));

  // R6: read/write at least two cycles after activate
  p_act_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_code == 3'd2 || cmd_code == 3'd3)) |-> since_act_q >= 4'd2);

  // R8: longest precharge spacing leaves three idle cycles
  p_pre_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 3'd4 && cfg_rdata[8:7] == 2'b00)
      |=> !cmd_valid ##1 !cmd_valid ##1 !cmd_valid);

  // R10: refresh lockout on everything but refresh
  p_ref_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code != 3'd5) |-> since_ref_q == 4'd15);

endmodule

bind sdram_cmd_gate sdram_cmd_gate_chk u_chk (.*);

// File: tb/sdram_cmd_gate_tb.sv
module sdram_cmd_gate_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [2:0]  req_cmd = '0;
  logic        req_ready, cmd_valid, rd_valid;
  logic [2:0]  cmd_code;
  logic [3:0]  col_bits;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sdram_cmd_gate u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_ready(req_ready), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .rd_valid(rd_valid), .col_bits(col_bits)
  );

  localparam logic [2:0] ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4, REF = 3'd5;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] word(input logic [1:0] col, input logic cl,
    input logic [1:0] rcd, input logic [1:0] wr, input logic [1:0] pre,
    input logic [1:0] rf);
    return {5'b0, rf, pre, wr, rcd, cl, col};
  endfunction

  task automatic write_cfg(input logic [15:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Issue a, then count sampling periods until b may transfer; b is issued
  task automatic gap(input logic [2:0] a, input logic [2:0] b, output int n);
    int w;
    @(negedge clk); req_valid = 1'b1; req_cmd = a; #1;
    w = 0;
    while (!req_ready && w < 40) begin @(negedge clk); #1; w++; end
    @(posedge clk);
    @(negedge clk); req_cmd = b; n = 1; #1;
    while (!req_ready && n < 40) begin @(negedge clk); n++; #1; end
    @(posedge clk);
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    chk("R1 cfg_rdata", cfg_rdata, 0);
    chk("R1 col_bits", col_bits, 8);
    chk("R1 rd_valid", rd_valid, 0);
    foreach (req_cmd[i]) ;
    req_cmd = ACT; #1; chk("R1 ready act", req_ready, 1);
    req_cmd = RD;  #1; chk("R1 ready rd", req_ready, 1);
    req_cmd = PRE; #1; chk("R1 ready pre", req_ready, 1);
    req_cmd = REF; #1; chk("R1 ready ref", req_ready, 1);
  endtask

  task automatic t_handshake;
    write_cfg(word(2'b00, 1'b0, 2'b00, 2'b00, 2'b00, 2'b10));
    idle(20);
    @(negedge clk); req_valid = 1'b0; req_cmd = ACT; #1;
    chk("R2 ready without valid", req_ready, 1);
    chk("R2 no issue without valid", cmd_valid, 0);
    @(negedge clk); req_cmd = RD; #1;
    chk("R2 unaccepted act starts no timer", req_ready, 1);
    for (int c = 0; c < 8; c += 6) begin
      @(negedge clk); req_valid = 1'b1; req_cmd = 3'(c); #1;
      chk("R2 illegal code ready", req_ready, 0);
      chk("R2 illegal code issue", cmd_valid, 0);
    end
    @(negedge clk); req_cmd = 3'd7; #1;
    chk("R2 code 7 ready", req_ready, 0);
    @(negedge clk); req_cmd = PRE; #1;
    chk("R2 issue same cycle", cmd_valid, 1);
    chk("R2 issued code", cmd_code, 4);
    @(negedge clk); req_valid = 1'b0;
    idle(6);
  endtask

  task automatic t_cfg;
    write_cfg(16'hFFFF); #1;
    chk("R3 readback masks 15:11", cfg_rdata, 16'h07FF);
    chk("R11 column code 11", col_bits, 10);
    write_cfg(16'hF801); #1;
    chk("R3 upper bits ignored", cfg_rdata, 16'h0001);
    chk("R4 column code 01", col_bits, 9);
    write_cfg(16'h0002); #1;
    chk("R4 column code 10", col_bits, 10);
    write_cfg(16'h0000); #1;
    chk("R4 column code 00", col_bits, 8);
  endtask

  task automatic t_act_rw;
    int n;
    logic [1:0] codes [4] = '{2'b10, 2'b11, 2'b00, 2'b01};
    int exp [4] = '{2, 3, 4, 4};
    foreach (codes[i]) begin
      write_cfg(word(2'b00, 1'b0, codes[i], 2'b01, 2'b01, 2'b10));
      idle(16);
      gap(ACT, RD, n);
      chk((i == 3) ? "R11 act-rw reserved" : "R6 act-rw", n, exp[i]);
    end
  endtask

  task automatic t_rw_pre;
    int n;
    for (int c = 0; c < 4; c++) begin
      write_cfg(word(2'b00, 1'b0, 2'b10, 2'(c), 2'b01, 2'b10));
      idle(16);
      gap(WR, PRE, n);
      chk("R7 rw-pre", n, (c == 0) ? 4 : c);
    end
    gap(RD, PRE, n);
    chk("R7 rd-pre", n, 3);
  endtask

  task automatic t_pre;
    int n;
    for (int c = 0; c < 4; c++) begin
      write_cfg(word(2'b00, 1'b0, 2'b10, 2'b01, 2'(c), 2'b10));
      idle(16);
      gap(PRE, ACT, n);
      chk("R8 pre-act", n, (c == 0) ? 4 : c);
    end
    gap(PRE, REF, n);
    chk("R8 pre-ref", n, 3);
  endtask

  task automatic t_ref;
    int n;
    logic [1:0] codes [4] = '{2'b10, 2'b11, 2'b00, 2'b01};
    int exp [4] = '{3, 7, 15, 15};
    foreach (codes[i]) begin
      write_cfg(word(2'b00, 1'b0, 2'b10, 2'b01, 2'b01, codes[i]));
      idle(16);
      gap(REF, REF, n);
      chk((i == 3) ? "R11 ref-ref reserved" : "R9 ref-ref", n, exp[i]);
    end
  endtask

  task automatic t_ref_any;
    int n;
    write_cfg(word(2'b00, 1'b0, 2'b10, 2'b01, 2'b01, 2'b10));
    idle(16);
    gap(REF, ACT, n);
    chk("R10 ref-act lockout", n, 15);
    idle(16);
    gap(REF, PRE, n);
    chk("R10 ref-pre lockout", n, 15);
  endtask

  task automatic strobe_run(input logic [2:0] c, output int first, output int cnt);
    @(negedge clk); req_valid = 1'b1; req_cmd = c; #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    first = 0; cnt = 0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk); req_valid = 1'b0; #1;
      if (rd_valid) begin cnt++; if (first == 0) first = k; end
    end
  endtask

  task automatic t_cas;
    int f, c;
    write_cfg(word(2'b00, 1'b0, 2'b10, 2'b01, 2'b01, 2'b10));
    idle(16);
    strobe_run(RD, f, c);
    chk("R5 cl2 position", f, 2);
    chk("R5 cl2 single pulse", c, 1);
    write_cfg(word(2'b00, 1'b1, 2'b10, 2'b01, 2'b01, 2'b10));
    strobe_run(RD, f, c);
    chk("R5 cl3 position", f, 3);
    chk("R5 cl3 single pulse", c, 1);
    strobe_run(WR, f, c);
    chk("R5 write no strobe", c, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_handshake();
    t_cfg();
    t_act_rw();
    t_rw_pre();
    t_pre();
    t_ref();
    t_ref_any();
    t_cas();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog all: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule